// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is a byte-wide parallel port pair, A and B, that moves data between a CPU bus and two peripherals under a strobe/acknowledge handshake. Each port is set as input or output by a configuration word. An input port captures the peripheral's data on a strobe, holds it until the CPU reads it, and flags the CPU that a byte is waiting. An output port holds the CPU's byte on its pins, tells the peripheral a byte is ready, and flags the CPU once the peripheral has acknowledged it.

Three lines of the 8-bit side port C belong to each handshake: one incoming strobe/acknowledge line, one buffer flag line and one interrupt request line. The two remaining port C lines are plain latched outputs or unlatched inputs. The CPU sees the handshake flags, the interrupt lines and the interrupt enables by reading port C. It sets each interrupt enable with a single-bit set/clear command aimed at the position of that port's strobe/acknowledge line.

Bus accesses are one clock wide and qualified by `cs`. Read data is combinational from the address. Pin inputs are taken as synchronous to `clk`.

Top module: `strobed_pport`

## Requirements
- R1: After reset both ports are inputs, the spare lines are inputs, every flag, interrupt and enable is 0, `pc_oe` is 8'h2B, `pa_oe`/`pb_oe` are 0 and reading port C returns only the spare pin levels in bits 7:6.
- R2: In input mode a high-to-low transition of the strobe line (port C bit 4 for A, bit 2 for B) latches the port pins into the data register and, on the same clock edge, raises the input-full flag (`pc_out` bit 5 for A, bit 1 for B). Pin changes while the strobe stays low are not captured.
- R3: A CPU read of an input port (address 0 for A, 1 for B) returns the latched byte and clears that port's input-full flag and interrupt request on that edge.
- R4: In input mode a low-to-high strobe transition with the input-full flag set and the enable set raises the interrupt request (`pc_out` bit 3 for A, bit 0 for B).
- R5: With the enable at 0 no interrupt request is raised. Clearing the enable drops a pending request one clock after the enable register changes.
- R6: In output mode a CPU write drives the byte on the port pins, asserts the port output enable and drives the active-low output-full line (same bit as the input-full flag) low.
- R7: In output mode a high-to-low acknowledge transition (bit 4 for A, bit 2 for B) drives output-full high. The following low-to-high transition with output-full high and the enable set raises the interrupt request. The next CPU write clears the request.
- R8: A control write (address 3) with bit 7 = 0 is a single-bit command: bits 3:1 select a port C position and bit 0 is the value. Position 4 writes enable A and position 2 writes enable B. Port C reads show enable A in bit 4 and enable B in bit 2.
- R9: The spare lines are port C bits 7:6. They are inputs when configuration bit 2 is 1 and outputs when it is 0. Their output latch is written by a port C write (data bits 7:6) or by single-bit commands on positions 6 and 7. A port C read returns the pins in input mode and the latch in output mode.
- R10: Single-bit commands on positions 0, 1, 3 and 5 change nothing, and a CPU write to an input-mode port changes neither its flags nor its data.
- R11: A control write with bit 7 = 1 loads the direction bits (bit 0 port A, bit 1 port B, bit 2 spare lines; 1 = input). On the same edge it clears all flags, requests, enables, data registers and the spare latch (output-full idles high).
- R12: A port C read returns {spare[1:0], flagA, enableA, intrA, enableB, flagB, intrB} from bit 7 down to bit 0. `pc_out` carries the flags and requests on bits 5, 3, 1, 0 with `pc_oe` set there, and bits 4 and 2 are never driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus select |
| rd | input | 1 | One-cycle read strobe |
| wr | input | 1 | One-cycle write strobe |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| pa_in | input | DATA_W | Port A pins in |
| pa_out | output | DATA_W | Port A pins out |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | DATA_W | Port B pins in |
| pb_out | output | DATA_W | Port B pins out |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins in (strobe/ack, spare inputs) |
| pc_out | output | 8 | Port C pins out (flags, requests, spare latch) |
| pc_oe | output | 8 | Port C per-line output enable |

## Verification
The hardest situation to reach is an interrupt that depends on ordering across separate events: a strobe edge, an enable written through a bit command, and a CPU read or write that may land one clock before or after it. The stimulus drives the strobe and acknowledge lines low and high on separate cycles, and it changes the pin data while the strobe is held low. Enables are set or cleared while an input-full flag is pending, so both the gating and the one-clock drop of a request are seen at `pc_out`. A configuration write issued while a port holds a pending request then shows that every piece of handshake state returns to idle.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  localparam int PC_W = 8;

  typedef enum logic [1:0] {
    SEL_PA  = 2'd0,
    SEL_PB  = 2'd1,
    SEL_PC  = 2'd2,
    SEL_CTL = 2'd3
  } hsp_sel_e;

  // port C positions; line positions double as enable command positions
  localparam logic [2:0] POS_INTR_B = 3'd0;
  localparam logic [2:0] POS_FLAG_B = 3'd1;
  localparam logic [2:0] POS_LINE_B = 3'd2;
  localparam logic [2:0] POS_INTR_A = 3'd3;
  localparam logic [2:0] POS_LINE_A = 3'd4;
  localparam logic [2:0] POS_FLAG_A = 3'd5;
  localparam logic [2:0] POS_SPR_0  = 3'd6;
  localparam logic [2:0] POS_SPR_1  = 3'd7;

  typedef struct packed {
    logic spare_in;
    logic b_in;
    logic a_in;
  } hsp_cfg_t;

  localparam hsp_cfg_t CFG_RESET = '{spare_in: 1'b1, b_in: 1'b1, a_in: 1'b1};

  function automatic int line_pos(input int port);
    return (port == 0) ? int'(POS_LINE_A) : int'(POS_LINE_B);
  endfunction

  function automatic logic [PC_W-1:0] pc_status(
    input logic [1:0] spare, input logic flag_a, input logic inte_a,
    input logic intr_a, input logic inte_b, input logic flag_b, input logic intr_b);
    return {spare, flag_a, inte_a, intr_a, inte_b, flag_b, intr_b};
  endfunction

  function automatic logic [PC_W-1:0] pc_drive(
    input logic [1:0] spare, input logic flag_a, input logic intr_a,
    input logic flag_b, input logic intr_b);
    return {spare, flag_a, 1'b0, intr_a, 1'b0, flag_b, intr_b};
  endfunction
endpackage

// File: rtl/hsp_port.sv
`timescale 1ns/1ps
module hsp_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         is_in,
  input  logic         inte,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         line_n,
  output logic [W-1:0] data_o,
  output logic         flag_o,
  output logic         intr_o
);
  logic         line_q, ibf_q, obf_n_q, intr_q;
  logic [W-1:0] data_q;

  // named events for the checks below
  wire line_fall = line_q & ~line_n;
  wire line_rise = ~line_q & line_n;
  wire in_rd     = is_in & cpu_rd;
  wire out_wr    = ~is_in & cpu_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b1;
      ibf_q   <= 1'b0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      line_q <= line_n;
      if (clr) begin
        ibf_q   <= 1'b0;
        obf_n_q <= 1'b1;
        intr_q  <= 1'b0;
        data_q  <= '0;
      end else if (is_in) begin
        if (line_fall) begin
          data_q <= pin_in;
          ibf_q  <= 1'b1;
        end else if (in_rd) begin
          ibf_q <= 1'b0;
        end
        if (in_rd || !inte)            intr_q <= 1'b0;
        else if (line_rise && ibf_q)   intr_q <= 1'b1;
      end else begin
        if (out_wr) begin
          data_q  <= wdata;
          obf_n_q <= 1'b0;
        end else if (line_fall) begin
          obf_n_q <= 1'b1;
        end
        if (out_wr || !inte)           intr_q <= 1'b0;
        else if (line_rise && obf_n_q) intr_q <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign flag_o = is_in ? ibf_q : obf_n_q;
  assign intr_o = intr_q;

  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_in && line_fall && !clr) |=> ibf_q); // R2
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && !line_fall && !clr) |=> (!ibf_q && !intr_q)); // R3
  AST_INTE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !inte |=> !intr_q); // R5
  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && !clr) |=> !obf_n_q); // R6
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_in && line_fall && !cpu_wr && !clr) |=> obf_n_q); // R7
  AST_INTR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(line_rise)); // R4
endmodule

// File: rtl/hsp_ctrl.sv
`timescale 1ns/1ps
module hsp_ctrl
  import hsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       pc_wr,
  input  logic [7:0] wbyte,
  output hsp_cfg_t   cfg,
  output logic       inte_a,
  output logic       inte_b,
  output logic [1:0] spare_q,
  output logic       mode_clr
);
  wire       mode_wr = ctl_wr & wbyte[7];
  wire       bsr_wr  = ctl_wr & ~wbyte[7];
  wire [2:0] bsr_pos = wbyte[3:1];
  wire       bsr_val = wbyte[0];
  wire       bsr_nop = bsr_wr && (bsr_pos == POS_INTR_B || bsr_pos == POS_FLAG_B ||
                                  bsr_pos == POS_INTR_A || bsr_pos == POS_FLAG_A);
  logic [1:0] unused_cw;
  assign unused_cw = wbyte[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= CFG_RESET;
      inte_a  <= 1'b0;
      inte_b  <= 1'b0;
      spare_q <= 2'b00;
    end else if (mode_wr) begin
      cfg     <= '{spare_in: wbyte[2], b_in: wbyte[1], a_in: wbyte[0]};
      inte_a  <= 1'b0;
      inte_b  <= 1'b0;
      spare_q <= 2'b00;
    end else if (bsr_wr) begin
      if (bsr_pos == POS_LINE_A) inte_a     <= bsr_val;
      if (bsr_pos == POS_LINE_B) inte_b     <= bsr_val;
      if (bsr_pos == POS_SPR_0)  spare_q[0] <= bsr_val;
      if (bsr_pos == POS_SPR_1)  spare_q[1] <= bsr_val;
    end else if (pc_wr) begin
      spare_q <= wbyte[7:6];
    end
  end

  assign mode_clr = mode_wr;

  AST_MODE_CLEARS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!inte_a && !inte_b && spare_q == 2'b00)); // R11
  AST_BSR_ENABLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_wr && bsr_pos == POS_LINE_A) |=> (inte_a == $past(bsr_val))); // R8
  AST_BSR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_nop |=> ($stable(inte_a) && $stable(inte_b) && $stable(spare_q))); // R10
endmodule

// File: rtl/strobed_pport.sv
`timescale 1ns/1ps
module strobed_pport
  import hsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe
);
  localparam int NPORT = 2;

  hsp_sel_e   sel;
  hsp_cfg_t   cfg;
  logic       inte_a, inte_b, mode_clr;
  logic [1:0] spare_q, spare_rd;

  logic [DATA_W-1:0] pin   [NPORT];
  logic [DATA_W-1:0] dat   [NPORT];
  logic [NPORT-1:0]  dir_in, inte, prd, pwr, flag, intr;
  logic [3:0]        unused_pc;

  assign sel       = hsp_sel_e'(addr);
  assign unused_pc = {pc_in[POS_FLAG_A], pc_in[POS_INTR_A], pc_in[POS_FLAG_B], pc_in[POS_INTR_B]};
  assign pin[0]    = pa_in;
  assign pin[1]    = pb_in;
  assign dir_in    = {cfg.b_in, cfg.a_in};
  assign inte      = {inte_b, inte_a};
  assign prd       = {cs && rd && sel == SEL_PB, cs && rd && sel == SEL_PA};
  assign pwr       = {cs && wr && sel == SEL_PB, cs && wr && sel == SEL_PA};

  hsp_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (cs && wr && sel == SEL_CTL),
    .pc_wr   (cs && wr && sel == SEL_PC),
    .wbyte   (wdata[7:0]),
    .cfg     (cfg),
    .inte_a  (inte_a),
    .inte_b  (inte_b),
    .spare_q (spare_q),
    .mode_clr(mode_clr)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam int LP = line_pos(i);
    hsp_port #(.W(DATA_W)) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_clr),
      .is_in (dir_in[i]),
      .inte  (inte[i]),
      .cpu_rd(prd[i]),
      .cpu_wr(pwr[i]),
      .wdata (wdata),
      .pin_in(pin[i]),
      .line_n(pc_in[LP]),
      .data_o(dat[i]),
      .flag_o(flag[i]),
      .intr_o(intr[i])
    );
  end

  assign spare_rd = cfg.spare_in ? pc_in[7:6] : spare_q;
  assign pa_out   = dat[0];
  assign pb_out   = dat[1];
  assign pa_oe    = ~cfg.a_in;
  assign pb_oe    = ~cfg.b_in;
  assign pc_out   = pc_drive(spare_q, flag[0], intr[0], flag[1], intr[1]);
  assign pc_oe    = {{2{~cfg.spare_in}}, 6'b101011};

  always_comb begin
    unique case (sel)
      SEL_PA:  rdata = dat[0];
      SEL_PB:  rdata = dat[1];
      SEL_PC:  rdata = DATA_W'(pc_status(spare_rd, flag[0], inte_a, intr[0],
                                         inte_b, flag[1], intr[1]));
      default: rdata = '0;
    endcase
  end

  AST_UNDRIVEN_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_oe[POS_LINE_A] && !pc_oe[POS_LINE_B] && !pc_out[POS_LINE_A] && !pc_out[POS_LINE_B])); // R12
endmodule

// File: tb/strobed_pport_tb_top.sv
`timescale 1ns/1ps
module strobed_pport_tb_top;
  logic       clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 8'hFF;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_pport dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic line_low(input int b);
    @(negedge clk); pc_in[b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic line_high(input int b);
    pc_in[b] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "pc_out", pc_out, 8'h00);
    chk("R1", "pc_oe", pc_oe, 8'h2B);
    chk("R1", "pa_oe/pb_oe", {pa_oe, pb_oe}, 2'b00);
    bus_rd(2, d);
    chk("R1", "portC status", d, 8'hC0);
  endtask

  task automatic t_input_a();
    logic [7:0] d;
    bus_wr(3, 8'h09);
    bus_rd(2, d);
    chk("R8", "enable A in status bit4", d[4], 1'b1);
    pa_in = 8'h5A;
    line_low(4);
    chk("R2", "input-full A after strobe fall", pc_out[5], 1'b1);
    pa_in = 8'h33;
    line_high(4);
    chk("R4", "intr A after strobe rise", pc_out[3], 1'b1);
    bus_rd(0, d);
    chk("R2", "latched A data", d, 8'h5A);
    chk("R3", "flag/intr A after read", {pc_out[5], pc_out[3]}, 2'b00);
  endtask

  task automatic t_input_b();
    logic [7:0] d;
    pb_in = 8'hC3;
    line_low(2);
    chk("R2", "input-full B", pc_out[1], 1'b1);
    line_high(2);
    chk("R5", "no intr B while disabled", pc_out[0], 1'b0);
    bus_wr(3, 8'h05);
    bus_rd(2, d);
    chk("R8", "enable B in status bit2", d[2], 1'b1);
    pb_in = 8'h96;
    line_low(2);
    line_high(2);
    chk("R4", "intr B with enable", pc_out[0], 1'b1);
    bus_wr(3, 8'h04);
    @(negedge clk);
    chk("R5", "intr B dropped by enable clear", pc_out[0], 1'b0);
    bus_rd(1, d);
    chk("R2", "B holds data of last fall", d, 8'h96);
    chk("R3", "input-full B after read", pc_out[1], 1'b0);
  endtask

  task automatic t_mode_clear();
    logic [7:0] d;
    bus_wr(3, 8'h05);
    pb_in = 8'h77;
    line_low(2);
    line_high(2);
    chk("R4", "pending intr B before mode set", pc_out[1:0], 2'b11);
    bus_wr(3, 8'h82);
    chk("R11", "pc_out after mode set", pc_out, 8'h20);
    chk("R11", "pc_oe after mode set", pc_oe, 8'hEB);
    chk("R11", "pa_oe/pb_oe", {pa_oe, pb_oe}, 2'b10);
    bus_rd(2, d);
    chk("R12", "status after mode set", d, 8'h20);
    bus_rd(1, d);
    chk("R11", "B data cleared", d, 8'h00);
  endtask

  task automatic t_output_a();
    logic [7:0] d;
    bus_wr(3, 8'h09);
    bus_wr(0, 8'hA5);
    chk("R6", "pa_out after write", pa_out, 8'hA5);
    chk("R6", "output-full A low", pc_out[5], 1'b0);
    line_low(4);
    chk("R7", "ack fall: obf high, no intr", {pc_out[5], pc_out[3]}, 2'b10);
    line_high(4);
    chk("R7", "intr A after ack rise", pc_out[3], 1'b1);
    bus_wr(0, 8'h11);
    chk("R7", "write clears intr, obf low", {pc_out[5], pc_out[3]}, 2'b00);
    bus_rd(0, d);
    chk("R6", "output port readback", d, 8'h11);
  endtask

  task automatic t_spare_and_ignored();
    logic [7:0] d;
    bus_wr(2, 8'h80);
    chk("R9", "spare from portC write", pc_out[7:6], 2'b10);
    bus_wr(3, 8'h0D);
    chk("R9", "spare bit6 set", pc_out[7:6], 2'b11);
    bus_wr(3, 8'h0E);
    chk("R9", "spare bit7 clear", pc_out[7:6], 2'b01);
    bus_wr(3, 8'h01);
    bus_wr(3, 8'h03);
    bus_wr(3, 8'h07);
    bus_wr(3, 8'h0B);
    chk("R10", "pc_out after ignored commands", pc_out, 8'h40);
    bus_rd(2, d);
    chk("R12", "status layout", d, 8'h50);
    bus_wr(1, 8'hFF);
    chk("R10", "input B flag after write", pc_out[1], 1'b0);
    bus_rd(1, d);
    chk("R10", "input B data after write", d, 8'h00);
    bus_wr(3, 8'h87);
    pc_in[7:6] = 2'b01;
    chk("R9", "spare oe in input mode", pc_oe[7:6], 2'b00);
    bus_rd(2, d);
    chk("R9", "spare pins read", d, 8'h40);
    chk("R11", "pa_oe after input config", pa_oe, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_input_a();
    t_input_b();
    t_mode_clear();
    t_output_a();
    t_spare_and_ignored();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule